// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Unit

This block is a small fixed-point SIMD datapath. Each element takes a multiplicand, a multiplier and an accumulator. The unit doubles the signed product of the first two and keeps the high half of that product. It adds this to the accumulator, or takes it away in the subtract mode, rounds to the nearest value and clamps the result to the signed element range. All of this is folded into one wide sum. The 32-bit operand words are read either as two independent 16-bit lanes or as one 32-bit lane.

Results are registered, so the packed result appears one clock after an accepted input strobe. A sticky saturation flag records that some lane has clamped since it was last cleared. The surrounding pipeline reads this flag to detect that precision was lost, and clears it with a synchronous clear input.

Top module: `sqrd_mac_unit`

## Requirements
- R1: In 16-bit mode (`wide_mode`=0, `sub_mode`=0), each lane computes ((acc << 15) + a*b + (1 << 14)) >>> 15 on signed 16-bit operands, without loss in the intermediate value.
- R2: In 16-bit mode, bits [15:0] of the three operands form lane 0, which drives `res_data[15:0]`. Bits [31:16] form lane 1, which drives `res_data[31:16]`. A lane never affects the other lane's result.
- R3: In 32-bit mode (`wide_mode`=1), the whole words are signed 32-bit operands, and the result is ((acc << 31) + a*b + (1 << 30)) >>> 31, computed without loss.
- R4: With `sub_mode`=1, the product is subtracted instead of added in both element sizes. The shift and the rounding constant stay the same.
- R5: A value that does not fit the signed element width clamps to 0x8000 / 0x80000000 when negative and to 0x7FFF / 0x7FFFFFFF when positive. This includes min*min with a zero accumulator.
- R6: An accepted operation (`in_valid`=1) in which any lane of the selected size clamps sets `sat_sticky` on the next clock.
- R7: `sat_sticky` stays high until cleared. It is not set by an operation that does not clamp, and it is not set by any input presented while `in_valid`=0.
- R8: `sat_clear`=1 clears `sat_sticky` on the next clock. If a clamping operation is accepted in the same cycle, the flag reads 1 afterwards.
- R9: `res_data` and `res_valid` are registered. `res_valid` is high exactly one cycle after `in_valid`. `res_data` holds its value while `in_valid`=0.
- R10: While `rst` is high, `res_data`, `res_valid` and `sat_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| sub_mode | input | 1 | 0 accumulate, 1 subtract |
| wide_mode | input | 1 | 0 two 16-bit lanes, 1 one 32-bit lane |
| op_a | input | 32 | Multiplicand word |
| op_b | input | 32 | Multiplier word |
| op_acc | input | 32 | Accumulator word |
| sat_clear | input | 1 | Synchronous clear of the sticky flag |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_data | output | 32 | Packed saturated result |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Two functions can fall in the same cycle: the clear of the sticky flag and the setting of that flag by a clamping operation. The bench raises the flag first. It then presents `sat_clear` together with a min*min operation, and separately together with an operation that does not clamp. It expects the flag at 1 in the first case and at 0 in the second. It also checks the flag after a clear on its own. Every result is compared with a wide-integer model of the rounding formula, over directed extremes, rounding ties and random operands.

// File: rtl/sqrd_pkg.sv
package sqrd_pkg;
  typedef enum logic {
    OP_ACC = 1'b0,
    OP_SUB = 1'b1
  } sqrd_op_e;

  typedef enum logic {
    SZ_HALF = 1'b0,
    SZ_FULL = 1'b1
  } sqrd_size_e;
endpackage

// File: rtl/sqrd_lane.sv
module sqrd_lane
  import sqrd_pkg::*;
#(
  parameter int W = 16
) (
  input  sqrd_op_e      op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  acc,
  output logic [W-1:0]  res,
  output logic          ovf
);
  localparam int WIDE = 2 * W + 2;
  localparam logic signed [WIDE-1:0] RND  = {{(WIDE-1){1'b0}}, 1'b1} << (W - 2);
  localparam logic [W-1:0]           MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]           MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [2*W-1:0]  prod;
  logic signed [WIDE-1:0] prod_x;
  logic signed [WIDE-1:0] acc_x;
  logic signed [WIDE-1:0] acc_sh;
  logic signed [WIDE-1:0] sum;
  logic signed [WIDE-1:0] shifted;
  logic [WIDE-W:0]        hi;

  always_comb begin
    prod    = $signed(a) * $signed(b);
    prod_x  = {{2{prod[2*W-1]}}, prod};
    acc_x   = {{(WIDE-W){acc[W-1]}}, acc};
    acc_sh  = acc_x <<< (W - 1);
    if (op == OP_SUB) sum = acc_sh - prod_x + RND;
    else              sum = acc_sh + prod_x + RND;
    shifted = sum >>> (W - 1);
    hi      = shifted[WIDE-1:W-1];
    ovf     = !((&hi) || !(|hi));
    if (ovf) res = shifted[WIDE-1] ? MINV : MAXV;
    else     res = shifted[W-1:0];
  end
endmodule

// File: rtl/sqrd_lane_bank.sv
module sqrd_lane_bank
  import sqrd_pkg::*;
#(
  parameter int DW = 32
) (
  input  sqrd_op_e      op,
  input  sqrd_size_e    size,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] acc,
  output logic [DW-1:0] res,
  output logic          sat
);
  localparam int NW = DW / 2;
  localparam int NL = DW / NW;

  logic [DW-1:0] res_n;
  logic [NL-1:0] ovf_n;
  logic [DW-1:0] res_w;
  logic          ovf_w;

  for (genvar i = 0; i < NL; i++) begin : g_half
    sqrd_lane #(.W(NW)) i_lane (
      .op  (op),
      .a   (a[i*NW +: NW]),
      .b   (b[i*NW +: NW]),
      .acc (acc[i*NW +: NW]),
      .res (res_n[i*NW +: NW]),
      .ovf (ovf_n[i])
    );
  end

  sqrd_lane #(.W(DW)) i_full (
    .op  (op),
    .a   (a),
    .b   (b),
    .acc (acc),
    .res (res_w),
    .ovf (ovf_w)
  );

  always_comb begin
    if (size == SZ_FULL) begin
      res = res_w;
      sat = ovf_w;
    end else begin
      res = res_n;
      sat = |ovf_n;
    end
  end
endmodule

// File: rtl/sqrd_sticky.sv
module sqrd_sticky (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (clr ? 1'b0 : flag) | (upd & hit);
  end
endmodule

// File: rtl/sqrd_mac_unit.sv
module sqrd_mac_unit
  import sqrd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          sub_mode,
  input  logic          wide_mode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] op_acc,
  input  logic          sat_clear,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          sat_sticky
);
  sqrd_op_e      op;
  sqrd_size_e    size;
  logic [DW-1:0] res_c;
  logic          sat_c;

  assign op   = sqrd_op_e'(sub_mode);
  assign size = sqrd_size_e'(wide_mode);

  sqrd_lane_bank #(.DW(DW)) i_bank (
    .op   (op),
    .size (size),
    .a    (op_a),
    .b    (op_b),
    .acc  (op_acc),
    .res  (res_c),
    .sat  (sat_c)
  );

  sqrd_sticky i_sticky (
    .clk  (clk),
    .rst  (rst),
    .upd  (in_valid),
    .hit  (sat_c),
    .clr  (sat_clear),
    .flag (sat_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= res_c;
    end
  end
endmodule

// File: rtl/sqrd_mac_chk.sv
module sqrd_mac_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          sat_clear,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic          sat_sticky
);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clear) |=> sat_sticky);

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !sat_sticky) |=> !sat_sticky);

  // R8
  clear_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_clear && !in_valid) |=> !sat_sticky);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_data));
endmodule

bind sqrd_mac_unit sqrd_mac_chk #(.DW(DW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .sat_clear  (sat_clear),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .sat_sticky (sat_sticky)
);

// File: tb/test_sqrd_mac_unit.sv
`timescale 1ns/1ps
module test_sqrd_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        sub_mode = 1'b0;
  logic        wide_mode = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] op_acc = '0;
  logic        sat_clear = 1'b0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        sat_sticky;

  int  n_chk = 0;
  int  n_fail = 0;
  logic        exp_sat = 1'b0;
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;

  sqrd_mac_unit #(.DW(32)) i_sqrd_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub_mode(sub_mode),
    .wide_mode(wide_mode), .op_a(op_a), .op_b(op_b), .op_acc(op_acc),
    .sat_clear(sat_clear), .res_valid(res_valid), .res_data(res_data),
    .sat_sticky(sat_sticky)
  );

  function automatic logic [15:0] ref16(input logic [15:0] a, b, c,
                                        input logic sub, output logic ovf);
    longint p, s;
    p = longint'($signed(a)) * longint'($signed(b));
    s = (longint'($signed(c)) <<< 15);
    s = sub ? (s - p + 64'sd16384) : (s + p + 64'sd16384);
    s = s >>> 15;
    ovf = 1'b0;
    if (s > 64'sd32767)       begin ovf = 1'b1; return 16'h7FFF; end
    else if (s < -64'sd32768) begin ovf = 1'b1; return 16'h8000; end
    return s[15:0];
  endfunction

  function automatic logic [31:0] ref32(input logic [31:0] a, b, c,
                                        input logic sub, output logic ovf);
    logic signed [127:0] p, s, ax, bx, cx;
    ax = $signed({{96{a[31]}}, a});
    bx = $signed({{96{b[31]}}, b});
    cx = $signed({{96{c[31]}}, c});
    p = ax * bx;
    s = cx <<< 31;
    s = sub ? (s - p + (128'sd1 <<< 30)) : (s + p + (128'sd1 <<< 30));
    s = s >>> 31;
    ovf = 1'b0;
    if (s > 128'sd2147483647)       begin ovf = 1'b1; return 32'h7FFFFFFF; end
    else if (s < -128'sd2147483648) begin ovf = 1'b1; return 32'h80000000; end
    return s[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one accepted operation and checks result, strobe and flag.
  task automatic run_op(input string req, input logic [31:0] a, b, c,
                        input logic sub, input logic wide, input logic clr);
    logic [31:0] exp;
    logic o0, o1, ow;
    if (wide) begin
      exp = ref32(a, b, c, sub, ow);
    end else begin
      exp[15:0]  = ref16(a[15:0],  b[15:0],  c[15:0],  sub, o0);
      exp[31:16] = ref16(a[31:16], b[31:16], c[31:16], sub, o1);
      ow = o0 | o1;
    end
    @(negedge clk);
    in_valid = 1'b1; sub_mode = sub; wide_mode = wide;
    op_a = a; op_b = b; op_acc = c; sat_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
    exp_sat = (clr ? 1'b0 : exp_sat) | ow;
    last_res = exp;
    check({req, " data"}, res_data, exp);
    check("R9 res_valid", {31'b0, res_valid}, 32'd1);
    check({req, " R6 sticky"}, {31'b0, sat_sticky}, {31'b0, exp_sat});
  endtask

  task automatic t_reset();
    check("R10 data", res_data, 32'h0);
    check("R10 valid", {31'b0, res_valid}, 32'd0);
    check("R10 sticky", {31'b0, sat_sticky}, 32'd0);
  endtask

  task automatic t_half_acc();
    run_op("R1", 32'h0002_0003, 32'h0004_0005, 32'h0010_0020, 1'b0, 1'b0, 1'b0);
    run_op("R1", 32'h4000_4000, 32'h4000_C000, 32'h1234_8765, 1'b0, 1'b0, 1'b0);
    run_op("R1 tie", 32'h0001_0001, 32'h4000_2000, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    run_op("R1 negtie", 32'hFFFF_FFFF, 32'h4000_2000, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lanes();
    run_op("R2 hi only", 32'h7FFF_0000, 32'h7FFF_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    run_op("R2 lo only", 32'h0000_1234, 32'h0000_5678, 32'hABCD_0000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_full();
    run_op("R3", 32'h4000_0000, 32'h2000_0000, 32'h0000_1000, 1'b0, 1'b1, 1'b0);
    run_op("R3 tie", 32'h0000_0001, 32'h4000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0);
    run_op("R4 full", 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_sub();
    run_op("R4", 32'h0100_7000, 32'h0200_7000, 32'h0400_0100, 1'b1, 1'b0, 1'b0);
    run_op("R4 min*min", 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    run_op("R5 min*min16", 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    run_op("R5 neg16", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h8000_8000, 1'b1, 1'b0, 1'b1);
    run_op("R5 min*min32", 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b1);
    run_op("R5 neg32", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_sticky();
    run_op("R6 set", 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b1);
    run_op("R7 keep", 32'h0001_0001, 32'h0001_0001, 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    sat_clear = 1'b1;
    @(negedge clk);
    sat_clear = 1'b0; exp_sat = 1'b0;
    check("R8 clear alone", {31'b0, sat_sticky}, 32'd0);
    run_op("R8 clear+sat", 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 1'b1);
    run_op("R8 clear+plain", 32'h0003_0003, 32'h0003_0003, 32'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h8000_8000; op_b = 32'h8000_8000; op_acc = 32'h0;
    wide_mode = 1'b0; sub_mode = 1'b0;
    @(negedge clk);
    check("R9 hold data", res_data, last_res);
    check("R9 valid low", {31'b0, res_valid}, 32'd0);
    check("R7 no set idle", {31'b0, sat_sticky}, {31'b0, exp_sat});
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      run_op("R1/R3/R4 rand", $urandom, $urandom, $urandom,
             1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 == 0));
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_half_acc();
    t_lanes();
    t_full();
    t_sub();
    t_saturate();
    t_sticky();
    t_hold();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule